// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned operands and a single carry input and returns the truncated sum plus a carry output. It has no clock and no state: the result follows the inputs through combinational logic alone, and a parent datapath samples it in its own registers.

The operand width is divided into equal groups, four bits wide by default, which gives four groups at sixteen bits. Inside a group the carry moves one bit at a time. Each bit forms a generate term (both operand bits high) and a propagate term (the operand bits differ). Each group also has a bypass multiplexer. When every bit of the group propagates, the bypass sends the group's incoming carry straight to the next group and the internal ripple is not used. In every other case the group's own ripple result sets the carry it passes on. The final carry output is the carry that leaves the most significant group's bypass multiplexer.

Top module: `carry_skip_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, that is, the carry out of the most significant bit.
- R3: A bit position where both operand bits are 1 (generate) always passes a carry of 1 into the next higher position, whatever its own incoming carry is.
- R4: The propagate term is the XOR of the two operand bits. A bit where both operands are 1 does not count as propagating, so its sum bit equals its incoming carry (for example 0x0001 + 0x0001 + 1 gives 0x0003).
- R5: When all bits of a group propagate, the carry leaving that group equals the carry entering it (for example 0xFFFF + 0x0000 gives 0x0000 with carry 1 when `cin_i` is 1, and 0xFFFF with carry 0 when `cin_i` is 0).
- R6: A carry generated in bit 0 with every higher bit propagating (the longest ripple-then-bypass-then-ripple path) reaches every sum bit and the carry output: 0xFFFF + 0x0001 gives sum 0 and carry 1.
- R7: A bit position where both operand bits are 0 (kill) passes a carry of 0 into the next higher position, whatever its own incoming carry is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (16) | First unsigned operand |
| b_i | input | WIDTH (16) | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH (16) | Low WIDTH bits of the sum |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The bench targets the longest carry path: a carry generated in bit 0 that ripples to the top of the first group, crosses the two middle groups through their bypasses and ripples again through the last group. An adder that dropped a bypass or broke the chain there would return a nonzero sum and no carry out. Operands with every bit propagating check that the incoming carry crosses all groups, so a bypass keyed on the wrong condition would leave a sum of 0xFFFF or drop the carry. Operands with both bits high at the same positions catch a propagate term formed with OR, which would clear sum bits that should equal the incoming carry. Kill patterns catch a carry that leaks past positions where both operand bits are zero.

// File: rtl/csk_pkg.sv
package csk_pkg;

    localparam int unsigned DEF_WIDTH   = 16;
    localparam int unsigned DEF_GROUP_W = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } bit_pg_t;

    function automatic bit_pg_t make_pg(input logic a, input logic b);
        bit_pg_t t;
        t.gen  = a & b;
        t.prop = a ^ b;
        return t;
    endfunction

    function automatic logic carry_step(input bit_pg_t t, input logic c);
        return t.gen | (t.prop & c);
    endfunction

endpackage

// File: rtl/csk_pg_gen.sv
module csk_pg_gen
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output bit_pg_t          pg_o [WIDTH]
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg_o[i] = make_pg(a_i[i], b_i[i]);
    end

endmodule

// File: rtl/csk_ripple_group.sv
module csk_ripple_group
    import csk_pkg::*;
#(
    parameter int unsigned GROUP_W = DEF_GROUP_W
) (
    input  bit_pg_t              pg_i [GROUP_W],
    input  logic                 cin_i,
    output logic [GROUP_W-1:0]   sum_o,
    output logic [GROUP_W-1:0]   bit_carry_o,
    output logic                 ripple_cout_o,
    output logic                 all_prop_o
);

    logic [GROUP_W:0]   chain;
    logic [GROUP_W-1:0] prop_vec;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < GROUP_W; i++) begin : g_stage
        assign prop_vec[i]    = pg_i[i].prop;
        assign sum_o[i]       = pg_i[i].prop ^ chain[i];
        assign chain[i+1]     = carry_step(pg_i[i], chain[i]);
        assign bit_carry_o[i] = chain[i];
    end

    assign ripple_cout_o = chain[GROUP_W];
    assign all_prop_o    = &prop_vec;

endmodule

// File: rtl/csk_skip_mux.sv
module csk_skip_mux (
    input  logic cin_i,
    input  logic ripple_cout_i,
    input  logic all_prop_i,
    output logic cout_o
);

    always_comb begin
        if (all_prop_i) cout_o = cin_i;
        else            cout_o = ripple_cout_i;
    end

endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH   = DEF_WIDTH,
    parameter int unsigned GROUP_W = DEF_GROUP_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned N_GROUPS = WIDTH / GROUP_W;

    bit_pg_t             pg [WIDTH];
    logic [N_GROUPS:0]   grp_carry;
    logic [N_GROUPS-1:0] grp_all_prop;
    logic [N_GROUPS-1:0] grp_ripple;
    logic [WIDTH:0]      carries;
    logic [WIDTH-1:0]    gen_vec;
    logic [WIDTH-1:0]    prop_vec;

    csk_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_i  (a_i),
        .b_i  (b_i),
        .pg_o (pg)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_flat
        assign gen_vec[i]  = pg[i].gen;
        assign prop_vec[i] = pg[i].prop;
    end

    assign grp_carry[0] = cin_i;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
        bit_pg_t grp_pg [GROUP_W];

        for (genvar j = 0; j < GROUP_W; j++) begin : g_slice
            assign grp_pg[j] = pg[g*GROUP_W + j];
        end

        csk_ripple_group #(.GROUP_W(GROUP_W)) u_ripple (
            .pg_i          (grp_pg),
            .cin_i         (grp_carry[g]),
            .sum_o         (sum_o[g*GROUP_W +: GROUP_W]),
            .bit_carry_o   (carries[g*GROUP_W +: GROUP_W]),
            .ripple_cout_o (grp_ripple[g]),
            .all_prop_o    (grp_all_prop[g])
        );

        csk_skip_mux u_skip (
            .cin_i         (grp_carry[g]),
            .ripple_cout_i (grp_ripple[g]),
            .all_prop_i    (grp_all_prop[g]),
            .cout_o        (grp_carry[g+1])
        );
    end

    assign carries[WIDTH] = grp_carry[N_GROUPS];
    assign cout_o         = grp_carry[N_GROUPS];

endmodule

// File: rtl/carry_skip_adder_chk.sv
module carry_skip_adder_chk #(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned GROUP_W = 4
) (
    input logic [WIDTH-1:0]           a_i,
    input logic [WIDTH-1:0]           b_i,
    input logic                       cin_i,
    input logic [WIDTH-1:0]           sum_o,
    input logic                       cout_o,
    input logic [WIDTH:0]             carries,
    input logic [WIDTH/GROUP_W:0]     grp_carry,
    input logic [WIDTH/GROUP_W-1:0]   grp_all_prop
);

    localparam int unsigned N_GROUPS = WIDTH / GROUP_W;

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        assert_sum_R1: assert (sum_o == ref_total[WIDTH-1:0]);
        assert_cout_R2: assert (cout_o == ref_total[WIDTH]);
        for (int i = 0; i < WIDTH; i++) begin
            if (a_i[i] & b_i[i]) begin
                assert_gen_R3: assert (carries[i+1] == 1'b1);
            end
            if (~a_i[i] & ~b_i[i]) begin
                assert_kill_R7: assert (carries[i+1] == 1'b0);
            end
            if (a_i[i] ^ b_i[i]) begin
                assert_xorprop_R4: assert (sum_o[i] == ~carries[i]);
            end
        end
        for (int g = 0; g < N_GROUPS; g++) begin
            if (grp_all_prop[g]) begin
                assert_skip_R5: assert (grp_carry[g+1] == grp_carry[g]);
            end
        end
    end

endmodule

bind carry_skip_adder carry_skip_adder_chk #(
    .WIDTH   (WIDTH),
    .GROUP_W (GROUP_W)
) u_chk (
    .a_i          (a_i),
    .b_i          (b_i),
    .cin_i        (cin_i),
    .sum_o        (sum_o),
    .cout_o       (cout_o),
    .carries      (carries),
    .grp_carry    (grp_carry),
    .grp_all_prop (grp_all_prop)
);

// File: tb/carry_skip_adder_tb.sv
module carry_skip_adder_tb;

    localparam int W = 16;

    logic         clk;
    logic         rst;
    logic [W-1:0] a, b, sum;
    logic         cin, cout;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 0;

    carry_skip_adder u_dut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic apply_and_check(input logic [W-1:0] va, input logic [W-1:0] vb,
                                   input logic vc, input string req);
        logic [W:0] exp;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        #1;
        n_checks++;
        if (sum !== exp[W-1:0] || cout !== exp[W]) begin
            n_errors++;
            $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
                     req, va, vb, vc, sum, cout, exp[W-1:0], exp[W]);
        end
    endtask

    task automatic t_reset_state();
        apply_and_check('0, '0, 1'b0, "R1");
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            apply_and_check(W'($urandom), W'($urandom), 1'($urandom), "R1/R2");
        end
    endtask

    task automatic t_generate();
        // R3: every bit generates; carry in of 0 and 1
        apply_and_check(16'hFFFF, 16'hFFFF, 1'b0, "R3");
        apply_and_check(16'hFFFF, 16'hFFFF, 1'b1, "R3");
        apply_and_check(16'h0008, 16'h0008, 1'b0, "R3");
        // R2: carry out from top generating bit only
        apply_and_check(16'h8000, 16'h8000, 1'b0, "R2");
    endtask

    task automatic t_xor_prop();
        // R4: 0x0001+0x0001+1 = 0x0003
        apply_and_check(16'h0001, 16'h0001, 1'b1, "R4");
        apply_and_check(16'h1111, 16'h1111, 1'b1, "R4");
        apply_and_check(16'hF0F0, 16'hF0F0, 1'b0, "R4");
    endtask

    task automatic t_skip();
        // R5: every group propagates
        apply_and_check(16'hFFFF, 16'h0000, 1'b1, "R5");
        apply_and_check(16'hFFFF, 16'h0000, 1'b0, "R5");
        apply_and_check(16'hA5A5, 16'h5A5A, 1'b1, "R5");
        apply_and_check(16'h0F0F, 16'hF0F0, 1'b1, "R5");
    endtask

    task automatic t_worst_path();
        // R6: carry made in bit 0, all higher bits propagate
        apply_and_check(16'hFFFF, 16'h0001, 1'b0, "R6");
        apply_and_check(16'hFFFE, 16'h0003, 1'b0, "R6");
        apply_and_check(16'h0001, 16'hFFFF, 1'b1, "R6");
    endtask

    task automatic t_kill();
        // R7: zero bits stop the carry
        apply_and_check(16'h0000, 16'h0000, 1'b1, "R7");
        apply_and_check(16'hFFEF, 16'h0000, 1'b1, "R7");
        apply_and_check(16'h7FFF, 16'h0000, 1'b1, "R7");
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_generate();
        t_xor_prop();
        t_skip();
        t_worst_path();
        t_kill();
        t_random();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule